// File: doc/BRIEF.md
# Edge-Triggered Priority Interrupt Controller

This block collects eight interrupt request lines, catches each rising edge in a request register, filters pending requests through a software mask, and picks a winner by fixed priority. When a winner exists and no acknowledge is in progress, it raises `int_o` toward the processor. The processor answers with two active-low pulses on `ack_n_i`. The first falling edge commits the winning line to the in-service register. The second falling edge produces an 8-bit vector: a programmable 5-bit base followed by the 3-bit line number. The vector is presented on `vec_o` with a one-cycle `vec_valid_o` strobe. There is no ready signal: the processor cannot stall the vector, so a consumer must take it in the cycle the strobe is high.

In-service bits nest. A pending request is presented only if it outranks every line already in service. The bits stay set until software writes an end-of-interrupt through the register port, which retires the highest-priority in-service line. If the request that raised `int_o` has disappeared by the first acknowledge falling edge, the sequence still completes, but with the lowest-priority line number 7 and without touching the in-service register. Software can therefore recognise a spurious interrupt by reading the in-service register. Request lines are brought into the clock domain through two flip-flops before edge detection.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request register (IRR) and the in-service register (ISR) read 0x00, the mask reads 0xFF, the vector base is 0, and `int_o` is 0.
- R2: A rising edge on `req_i[n]` sets IRR bit n whether or not mask bit n is set, and the bit stays set while the line stays high.
- R3: `int_o` is 1 exactly when some IRR bit n has mask bit n clear and no ISR bit at index n or below. A masked line never raises it.
- R4: An IRR bit whose request has not been acknowledged returns to 0 once its line goes low.
- R5: Priority is fixed, with the lowest index winning. The vector returned on the second acknowledge falling edge is {base[4:0], index[2:0]}.
- R6: At the first acknowledge falling edge, the winner's ISR bit is set, its IRR bit is cleared, and `int_o` drops. The IRR bit then stays 0 while the line is held high.
- R7: If no unmasked request can win at the first acknowledge falling edge, the vector is {base, 3'd7} and the ISR is left unchanged.
- R8: While ISR bit k is set, requests at index k and above do not raise `int_o`, but a request with a lower index does.
- R9: An end-of-interrupt write clears only the lowest-index set ISR bit.
- R10: The register port works as follows. Address 0 writes and reads the mask. Address 1 writes the base from `reg_wdata_i[7:3]`. Address 2 is the end-of-interrupt command (a write; its data is ignored). Reads return the mask at address 0, the IRR at address 1, the ISR at address 2, and {base, 3'b000} at address 3.
- R11: `vec_valid_o` is high for exactly one cycle, in the cycle after the clock edge that samples the second falling edge of `ack_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Interrupt request lines, asynchronous |
| ack_n_i | input | 1 | Active-low acknowledge from the processor, synchronous to clk |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector byte, held between deliveries |
| vec_valid_o | output | 1 | One-cycle strobe marking a new vector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |

## Verification
All 255 nonzero request patterns are raised at once with nothing masked. Each pattern is followed by a full acknowledge and an end-of-interrupt. This separates a correct lowest-index winner from any other choice and shows that only the winner's IRR bit is consumed. All 256 mask values are swept with every line high, which tells the masked and unmasked paths apart while the IRR still shows all eight lines. A nested sequence, a request that vanishes before acknowledge, and a masked line that rises and then falls isolate the in-service gating, the default vector that leaves the ISR untouched, and an IRR that follows the line.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_LINES  = 8;
  localparam int IRQ_BASE_W = 5;

  typedef enum logic {
    ACK_IDLE   = 1'b0,
    ACK_SECOND = 1'b1
  } ack_state_e;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_BASE = 2'd1;
  localparam logic [1:0] ADDR_EOI  = 2'd2;
  localparam logic [1:0] ADDR_RD_BASE = 2'd3;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int W    = 8,
  parameter int ID_W = $clog2(W)
) (
  input  logic [W-1:0]    pend_i,
  input  logic [W-1:0]    block_i,
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    any_o   = 1'b0;
    id_o    = '0;
    for (int i = 0; i < W; i++) begin
      blocked = blocked | block_i[i];
      if (!blocked && !any_o && pend_i[i]) begin
        any_o = 1'b1;
        id_o  = ID_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (any_o && (ID_W'(i) <= id_o))
        assert_nest_R8: assert (!block_i[i]);
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int ID_W   = 3,
  parameter int BASE_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ack_n_i,
  input  logic                   win_any_i,
  input  logic [ID_W-1:0]        win_id_i,
  input  logic [BASE_W-1:0]      base_i,
  output logic                   busy_o,
  output logic                   take_o,
  output logic [ID_W-1:0]        take_id_o,
  output logic [BASE_W+ID_W-1:0] vec_o,
  output logic                   vec_valid_o
);
  import irq_pkg::*;

  localparam logic [ID_W-1:0] DEFAULT_ID = '1;

  ack_state_e      state_q;
  logic            ack_prev_q;
  logic            fall;
  logic [ID_W-1:0] hold_id_q;
  logic            spur_q;

  assign fall      = ack_prev_q & ~ack_n_i;
  assign busy_o    = (state_q == ACK_SECOND);
  assign take_o    = (state_q == ACK_IDLE) && fall && win_any_i;
  assign take_id_o = win_id_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ACK_IDLE;
      ack_prev_q  <= 1'b1;
      hold_id_q   <= '0;
      spur_q      <= 1'b0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      ack_prev_q  <= ack_n_i;
      vec_valid_o <= 1'b0;
      unique case (state_q)
        ACK_IDLE: if (fall) begin
          state_q   <= ACK_SECOND;
          hold_id_q <= win_any_i ? win_id_i : DEFAULT_ID;
          spur_q    <= !win_any_i;
        end
        ACK_SECOND: if (fall) begin
          state_q     <= ACK_IDLE;
          vec_o       <= {base_i, hold_id_q};
          vec_valid_o <= 1'b1;
        end
        default: state_q <= ACK_IDLE;
      endcase
    end
  end

  assert_vec_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);

  assert_spur_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && spur_q) |-> (vec_o[ID_W-1:0] == DEFAULT_ID));

  assert_no_take_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !take_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int LINES  = irq_pkg::IRQ_LINES,
  parameter int BASE_W = irq_pkg::IRQ_BASE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             ack_n_i,
  output logic             int_o,
  output logic [7:0]       vec_o,
  output logic             vec_valid_o,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o
);
  import irq_pkg::*;

  localparam int ID_W  = $clog2(LINES);
  localparam int VEC_W = BASE_W + ID_W;

  logic [LINES-1:0]  req_lvl, req_rise;
  logic [LINES-1:0]  irr_q, isr_q, mask_q;
  logic [BASE_W-1:0] base_q;
  logic              win_any, eoi_any;
  logic [ID_W-1:0]   win_id, eoi_id;
  logic              busy, take;
  logic [ID_W-1:0]   take_id;
  logic [VEC_W-1:0]  vec_raw;
  logic [LINES-1:0]  take_bits, eoi_bits;
  logic              eoi_wr;

  irq_edge_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(req_i),
    .level_o(req_lvl), .rise_o(req_rise)
  );

  irq_prio_pick #(.W(LINES), .ID_W(ID_W)) u_win (
    .pend_i(irr_q & ~mask_q), .block_i(isr_q),
    .any_o(win_any), .id_o(win_id)
  );

  irq_prio_pick #(.W(LINES), .ID_W(ID_W)) u_eoi (
    .pend_i(isr_q), .block_i('0),
    .any_o(eoi_any), .id_o(eoi_id)
  );

  irq_ack_seq #(.ID_W(ID_W), .BASE_W(BASE_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack_n_i(ack_n_i),
    .win_any_i(win_any), .win_id_i(win_id), .base_i(base_q),
    .busy_o(busy), .take_o(take), .take_id_o(take_id),
    .vec_o(vec_raw), .vec_valid_o(vec_valid_o)
  );

  assign eoi_wr    = reg_wr_i && (reg_addr_i == ADDR_EOI);
  assign take_bits = take ? (LINES'(1) << take_id) : '0;
  assign eoi_bits  = (eoi_wr && eoi_any) ? (LINES'(1) << eoi_id) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '1;
      base_q <= '0;
    end else begin
      irr_q <= (irr_q | req_rise) & req_lvl & ~take_bits;
      isr_q <= (isr_q & ~eoi_bits) | take_bits;
      if (reg_wr_i && reg_addr_i == ADDR_MASK) mask_q <= reg_wdata_i[LINES-1:0];
      if (reg_wr_i && reg_addr_i == ADDR_BASE) base_q <= reg_wdata_i[7 -: BASE_W];
    end
  end

  assign int_o = win_any && !busy;
  assign vec_o = 8'(vec_raw);

  always_comb begin
    unique case (reg_addr_i)
      ADDR_MASK:    reg_rdata_o = 8'(mask_q);
      ADDR_BASE:    reg_rdata_o = 8'(irr_q);
      ADDR_EOI:     reg_rdata_o = 8'(isr_q);
      ADDR_RD_BASE: reg_rdata_o = 8'({base_q, {ID_W{1'b0}}});
      default:      reg_rdata_o = '0;
    endcase
  end

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr_q & ~mask_q) != '0));

  assert_take_sets_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> isr_q[$past(take_id)]);

  assert_take_clears_irr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !irr_q[$past(take_id)]);

  assert_eoi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !take) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))) || ($past(isr_q) == '0));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] req = '0;
  logic       ack_n = 1;
  logic       int_o, vec_valid;
  logic [7:0] vec, rdata;
  logic       wr = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_n_i(ack_n),
    .int_o(int_o), .vec_o(vec), .vec_valid_o(vec_valid),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(string req_tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic ack_seq(output logic [7:0] v, output logic vld, output logic v_after);
    ack_n = 0; repeat (2) @(negedge clk);
    ack_n = 1; repeat (2) @(negedge clk);
    ack_n = 0; @(negedge clk);
    vld = vec_valid; v = vec;
    ack_n = 1; @(negedge clk);
    v_after = vec_valid;
    @(negedge clk);
  endtask

  function automatic int low_idx(logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return 8;
  endfunction

  localparam logic [4:0] BASE = 5'b10101;

  initial begin
    logic [7:0] r, v;
    logic vld, va;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_reg(2'd0, r); chk("R1 mask", r, 8'hFF);
    rd_reg(2'd1, r); chk("R1 irr", r, 8'h00);
    rd_reg(2'd2, r); chk("R1 isr", r, 8'h00);
    rd_reg(2'd3, r); chk("R1 base", r, 8'h00);
    chk("R1 int", {7'd0, int_o}, 8'h00);

    // R10 base write and readback
    wr_reg(2'd1, {BASE, 3'b111});
    rd_reg(2'd3, r); chk("R10 base read", r, {BASE, 3'b000});

    // R2/R4 masked line raises IRR, follows line, no int
    req = 8'h10; settle();
    rd_reg(2'd1, r); chk("R2 masked irr set", r, 8'h10);
    chk("R3 masked no int", {7'd0, int_o}, 8'h00);
    req = 8'h00; settle();
    rd_reg(2'd1, r); chk("R4 irr follows line", r, 8'h00);

    // R3 mask sweep with all lines high
    req = 8'hFF; settle();
    for (int m = 0; m < 256; m++) begin
      wr_reg(2'd0, 8'(m));
      rd_reg(2'd0, r); chk("R10 mask read", r, 8'(m));
      rd_reg(2'd1, r); chk("R2 irr all", r, 8'hFF);
      chk("R3 int vs mask", {7'd0, int_o}, {7'd0, (8'(m) != 8'hFF)});
    end
    req = 8'h00; settle();
    wr_reg(2'd0, 8'h00);

    // R5/R6/R9/R11 sweep over request patterns
    for (int p = 1; p < 256; p++) begin
      int w;
      logic [7:0] pb, rest;
      pb = 8'(p);
      w = low_idx(pb);
      rest = pb & ~(8'd1 << w);
      req = pb; settle();
      chk("R3 int pending", {7'd0, int_o}, 8'h01);
      ack_seq(v, vld, va);
      chk("R11 valid", {7'd0, vld}, 8'h01);
      chk("R11 one cycle", {7'd0, va}, 8'h00);
      chk("R5 vector", v, {BASE, 3'(w)});
      rd_reg(2'd2, r); chk("R6 isr set", r, 8'd1 << w);
      rd_reg(2'd1, r); chk("R6 irr consumed", r, rest);
      chk("R6 int drops", {7'd0, int_o}, 8'h00);
      wr_reg(2'd2, 8'h00);
      rd_reg(2'd2, r); chk("R9 eoi clears", r, 8'h00);
      chk("R8 int after eoi", {7'd0, int_o}, {7'd0, (rest != 0)});
      req = 8'h00; settle();
      rd_reg(2'd1, r); chk("R4 irr cleared", r, 8'h00);
    end

    // R8 nesting, R6 hold, R9 single clear
    req = 8'h20; settle();
    ack_seq(v, vld, va);
    chk("R5 vector nest5", v, {BASE, 3'd5});
    rd_reg(2'd1, r); chk("R6 irr stays 0 while high", r, 8'h00);
    req = 8'h60; settle();
    chk("R8 lower blocked", {7'd0, int_o}, 8'h00);
    req = 8'h64; settle();
    chk("R8 higher passes", {7'd0, int_o}, 8'h01);
    ack_seq(v, vld, va);
    chk("R5 vector nest2", v, {BASE, 3'd2});
    rd_reg(2'd2, r); chk("R8 isr nested", r, 8'h24);
    wr_reg(2'd2, 8'h00);
    rd_reg(2'd2, r); chk("R9 clears lowest only", r, 8'h20);
    chk("R8 still blocked", {7'd0, int_o}, 8'h00);
    wr_reg(2'd2, 8'h00);
    rd_reg(2'd2, r); chk("R9 second eoi", r, 8'h00);
    chk("R8 line6 released", {7'd0, int_o}, 8'h01);
    req = 8'h00; settle();

    // R7 request vanishes before acknowledge
    req = 8'h08; settle();
    chk("R7 int up", {7'd0, int_o}, 8'h01);
    req = 8'h00; settle();
    ack_seq(v, vld, va);
    chk("R7 valid", {7'd0, vld}, 8'h01);
    chk("R7 default vector", v, {BASE, 3'd7});
    rd_reg(2'd2, r); chk("R7 isr untouched", r, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule